// File: doc/BRIEF.md
# Mute and Play Gain Ramp Sequencer

This block orders the switch-on and switch-off of one class-D amplifier channel so that neither produces an audible click. From a play/mute control level, a two-bit gain choice and a fault request, it produces three things: a gain code in whole decibels for the preamplifier gain network, a ramp code for the output common-mode level, and the enable for PWM switching.

On play, switching starts and the common-mode level rises first. Once it is at full scale, the gain climbs one decibel at a time to the selected target. On mute, the same steps run in reverse: the gain falls to zero, the common-mode level falls to zero, and switching then stops. The rate of each ramp is set by a prescaler parameter. A change of target during play moves the gain one decibel per gain step. A command that arrives part-way through a ramp reverses that ramp from its present value. A fault skips every ramp and forces high impedance in the next cycle.

Top module: `mute_ramp_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with play_i low, gain_o and cm_o are 0 and pwm_en_o is 0.
- R2: gain_sel_i selects the gain target in dB, and gain_o reports it in dB: 0 gives 12, 1 gives 20, 2 gives 26, 3 gives 32. Once gain_o reaches the target it holds there.
- R3: When play_i is sampled high in high impedance with no fault, pwm_en_o is 1 after that edge. cm_o then rises by 1 every CM_DIV cycles up to CM_STEPS. gain_o is never nonzero unless cm_o equals CM_STEPS.
- R4: Counting the sampling edge of play_i as edge 1, gain_o first equals target T after edge 2 + CM_STEPS*CM_DIV + T*GAIN_DIV. gain_o rises by 1 every GAIN_DIV cycles.
- R5: Taking the edge that samples play_i low from a settled play state as edge 1, gain_o reaches 0 after edge 1 + T*GAIN_DIV, while cm_o is still CM_STEPS. pwm_en_o falls to 0 after edge 3 + T*GAIN_DIV + CM_STEPS*CM_DIV.
- R6: A change of gain_sel_i during settled play moves gain_o by 1 per step toward the new target. The new target is reached |new-old|*GAIN_DIV cycles after the change.
- R7: A mute during a gain ramp-up, or a play during a gain ramp-down, reverses the ramp from the present value. gain_o never changes by more than 1 per cycle, except when a fault clears it.
- R8: When fault_i is sampled high, gain_o, cm_o and pwm_en_o are all 0 after that edge, and they stay 0 while fault_i is high even with play_i high. Once fault_i is released with play_i high, the full start-up sequence of R4 runs again.
- R9: A mute during the common-mode ramp-up turns cm_o back down from its present value to 0 without exceeding it. gain_o stays 0 throughout, and pwm_en_o then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| play_i | input | 1 | 1 = play, 0 = mute |
| gain_sel_i | input | 2 | Gain target select (R2 encoding) |
| fault_i | input | 1 | Fault request, forces high impedance |
| gain_o | output | GAIN_W (6) | Gain code in dB |
| cm_o | output | CM_W | Common-mode ramp code, 0 to CM_STEPS |
| pwm_en_o | output | 1 | PWM switching enable |

## Verification
The step-size assertions assume that gain_sel_i and play_i are synchronous to clk_i and that fault_i is the only input that may clear the ramps. The bench drives every input just after a rising edge, so each input is stable for a whole cycle. The sweep covers every gain target from a cold start and every ordered pair of targets during play. It also reverses ramps part-way and applies faults both in settled play and during the common-mode rise. It uses prescalers of 2 and 3 and 8 common-mode steps, so every expected cycle count is a small closed-form sum.

// File: rtl/mgr_pkg.sv
package mgr_pkg;
  localparam int unsigned GAIN_W = 6;

  typedef enum logic [2:0] {
    ST_HIZ, ST_CM_UP, ST_PLAY, ST_GAIN_DN, ST_CM_DN
  } seq_state_e;

  function automatic logic [GAIN_W-1:0] target_db(input logic [1:0] sel);
    case (sel)
      2'd0:    return GAIN_W'(12);
      2'd1:    return GAIN_W'(20);
      2'd2:    return GAIN_W'(26);
      default: return GAIN_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/mgr_tick.sv
module mgr_tick #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || tick_o)    cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/mgr_stepper.sv
module mgr_stepper #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] tgt_i,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      val_o <= '0;
    else if (clr_i)                   val_o <= '0;
    else if (tick_i && val_o < tgt_i) val_o <= val_o + 1'b1;
    else if (tick_i && val_o > tgt_i) val_o <= val_o - 1'b1;
  end

  // no jumps: unit step or hold unless cleared (R7)
  assert_unit_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (val_o == $past(val_o) || val_o == $past(val_o) + 1'b1 ||
                val_o == $past(val_o) - 1'b1));
  assert_no_overshoot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && val_o <= tgt_i) |=> val_o <= $past(tgt_i));
endmodule

// File: rtl/mute_ramp_ctrl.sv
module mute_ramp_ctrl
  import mgr_pkg::*;
#(
  parameter int unsigned GAIN_DIV = 16,
  parameter int unsigned CM_DIV   = 16,
  parameter int unsigned CM_STEPS = 32,
  localparam int unsigned CM_W    = $clog2(CM_STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              play_i,
  input  logic [1:0]        gain_sel_i,
  input  logic              fault_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [CM_W-1:0]   cm_o,
  output logic              pwm_en_o
);
  localparam logic [CM_W-1:0] CM_FULL = CM_W'(CM_STEPS);

  seq_state_e state_q, state_d;
  logic [GAIN_W-1:0] gain_tgt;
  logic [CM_W-1:0]   cm_tgt;
  logic gain_en, cm_en, gain_tick, cm_tick;

  assign gain_tgt = (state_q == ST_PLAY) ? target_db(gain_sel_i) : '0;
  assign cm_tgt   = (state_q == ST_CM_UP || state_q == ST_PLAY ||
                     state_q == ST_GAIN_DN) ? CM_FULL : '0;
  assign gain_en  = !fault_i && (state_q == ST_PLAY || state_q == ST_GAIN_DN)
                    && (gain_o != gain_tgt);
  assign cm_en    = !fault_i && (state_q == ST_CM_UP || state_q == ST_CM_DN)
                    && (cm_o != cm_tgt);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HIZ:     if (play_i)                state_d = ST_CM_UP;
      ST_CM_UP:   if (!play_i)               state_d = ST_CM_DN;
                  else if (cm_o == CM_FULL)  state_d = ST_PLAY;
      ST_PLAY:    if (!play_i)               state_d = ST_GAIN_DN;
      ST_GAIN_DN: if (play_i)                state_d = ST_PLAY;
                  else if (gain_o == '0)     state_d = ST_CM_DN;
      ST_CM_DN:   if (play_i)                state_d = ST_CM_UP;
                  else if (cm_o == '0)       state_d = ST_HIZ;
      default:                               state_d = ST_HIZ;
    endcase
    if (fault_i) state_d = ST_HIZ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HIZ;
    else         state_q <= state_d;
  end

  assign pwm_en_o = (state_q != ST_HIZ);

  mgr_tick #(.DIV(GAIN_DIV)) u_gain_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(gain_en), .tick_o(gain_tick));
  mgr_tick #(.DIV(CM_DIV)) u_cm_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cm_en), .tick_o(cm_tick));

  mgr_stepper #(.W(GAIN_W)) u_gain_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(fault_i), .tick_i(gain_tick),
    .tgt_i(gain_tgt), .val_o(gain_o));
  mgr_stepper #(.W(CM_W)) u_cm_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(fault_i), .tick_i(cm_tick),
    .tgt_i(cm_tgt), .val_o(cm_o));

  assert_gain_needs_cm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_o != '0) |-> (cm_o == CM_FULL));
  assert_fault_hiz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (gain_o == '0 && cm_o == '0 && !pwm_en_o));
  assert_off_is_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_en_o |-> (gain_o == '0 && cm_o == '0));
  assert_gain_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_o <= GAIN_W'(32));
endmodule

// File: tb/mute_ramp_ctrl_test.sv
module mute_ramp_ctrl_test;
  localparam int GD = 2;
  localparam int CD = 3;
  localparam int CS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic play = 1'b0;
  logic [1:0] sel = 2'd0;
  logic fault = 1'b0;
  logic [5:0] gain;
  logic [3:0] cm;
  logic pwm;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  mute_ramp_ctrl #(.GAIN_DIV(GD), .CM_DIV(CD), .CM_STEPS(CS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .play_i(play), .gain_sel_i(sel),
    .fault_i(fault), .gain_o(gain), .cm_o(cm), .pwm_en_o(pwm));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int tdb(input int s);
    return (s == 0) ? 12 : (s == 1) ? 20 : (s == 2) ? 26 : 32;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // R3 R4: cold start to target, checks ordering each cycle
  task automatic start_play(input int s);
    int n = 0, viol = 0, pwm1 = 0;
    sel = 2'(s); play = 1'b1;
    while (gain != 6'(tdb(s)) && n < 2000) begin
      step(); n++;
      if (n == 1) pwm1 = pwm;
      if (gain != 0 && cm != 4'(CS)) viol++;
    end
    chk("R3 pwm on after first edge", pwm1, 1);
    chk("R3 gain only with full cm", viol, 0);
    chk("R4 cycles to target", n, 2 + CS * CD + tdb(s) * GD);
  endtask

  // R5: mute from settled play at target t
  task automatic go_mute(input int t);
    int n = 0, zero_at = -1, cm_at = -1;
    play = 1'b0;
    while (pwm && n < 2000) begin
      step(); n++;
      if (gain == 0 && zero_at < 0) begin zero_at = n; cm_at = cm; end
    end
    chk("R5 gain zero cycle", zero_at, 1 + t * GD);
    chk("R5 cm full when gain zero", cm_at, CS);
    chk("R5 pwm off cycle", n, 3 + t * GD + CS * CD);
    chk("R5 cm zero at off", cm, 0);
  endtask

  initial begin
    int n, prev, maxv, minv, jumps;
    // R1
    step(); step();
    chk("R1 gain in reset", gain, 0);
    chk("R1 cm in reset", cm, 0);
    chk("R1 pwm in reset", pwm, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step();
    chk("R1 gain idle", gain, 0);
    chk("R1 pwm idle", pwm, 0);

    // R2 R4 R5: every target from cold
    for (int s = 0; s < 4; s++) begin
      start_play(s);
      for (int i = 0; i < 10; i++) step();
      chk("R2 target held", gain, tdb(s));
      go_mute(tdb(s));
    end

    // R6: every ordered pair during play
    start_play(0);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        if (a == b) continue;
        sel = 2'(a);
        n = 0;
        while (gain != 6'(tdb(a)) && n < 500) begin step(); n++; end
        step();
        sel = 2'(b); n = 0; jumps = 0; prev = gain;
        while (gain != 6'(tdb(b)) && n < 500) begin
          step(); n++;
          if (gain > prev + 1 || gain + 1 < prev) jumps++;
          prev = gain;
        end
        chk("R6 retarget cycles", n, (tdb(a) > tdb(b) ? tdb(a) - tdb(b) : tdb(b) - tdb(a)) * GD);
        chk("R6 unit steps", jumps, 0);
      end
    sel = 2'd0;
    n = 0;
    while (gain != 6'd12 && n < 500) begin step(); n++; end
    go_mute(12);

    // R7: reversal mid-ramp
    sel = 2'd3; play = 1'b1; n = 0;
    while (gain != 6'd10 && n < 2000) begin step(); n++; end
    play = 1'b0; maxv = gain; jumps = 0; prev = gain; n = 0;
    while (gain != 6'd4 && n < 500) begin
      step(); n++;
      if (gain > maxv) maxv = gain;
      if (gain > prev + 1 || gain + 1 < prev) jumps++;
      prev = gain;
    end
    chk("R7 no rise after mute", maxv, 10);
    chk("R7 reached 4 going down", gain, 4);
    play = 1'b1; minv = gain; n = 0;
    while (gain != 6'd32 && n < 500) begin
      step(); n++;
      if (gain < minv) minv = gain;
      if (gain > prev + 1 || gain + 1 < prev) jumps++;
      prev = gain;
    end
    chk("R7 no fall after play", minv, 4);
    chk("R7 back to target", gain, 32);
    chk("R7 unit steps", jumps, 0);

    // R8: fault in settled play
    fault = 1'b1; step();
    chk("R8 gain cleared", gain, 0);
    chk("R8 cm cleared", cm, 0);
    chk("R8 pwm off", pwm, 0);
    maxv = 0;
    for (int i = 0; i < 10; i++) begin step(); if (pwm || gain != 0 || cm != 0) maxv++; end
    chk("R8 stays off under fault", maxv, 0);
    fault = 1'b0; n = 0;
    while (gain != 6'd32 && n < 2000) begin step(); n++; end
    chk("R8 restart timing", n, 2 + CS * CD + 32 * GD);
    // R8: fault during cm rise
    go_mute(32);
    play = 1'b1; n = 0;
    while (cm != 4'd3 && n < 200) begin step(); n++; end
    fault = 1'b1; step();
    chk("R8 cm cleared mid ramp", cm, 0);
    chk("R8 pwm off mid ramp", pwm, 0);
    fault = 1'b0; play = 1'b0; step(); step();
    chk("R8 stays idle", pwm, 0);

    // R9: mute during cm rise
    play = 1'b1; n = 0;
    while (cm != 4'd4 && n < 200) begin step(); n++; end
    play = 1'b0; maxv = cm; minv = 0; n = 0;
    while (pwm && n < 200) begin
      step(); n++;
      if (cm > maxv) maxv = cm;
      if (gain != 0) minv++;
    end
    chk("R9 cm never above reversal point", maxv, 4);
    chk("R9 gain stayed zero", minv, 0);
    chk("R9 pwm off", pwm, 0);
    chk("R9 cm at zero", cm, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule